// File: doc/BRIEF.md
# Interface Initialise Sequencer

This block carries out the channel initialise command against the register file of an IEEE-488 bus interface, and it returns a two-way condition code. A one-cycle start strobe launches a fixed series of register reads and writes on a simple single-cycle register bus. The series makes two early checks and can end after either one. If it continues, it puts the interface online, drives remote enable and interface clear, and keeps interface clear asserted for a timed window counted in microsecond ticks. It then clears all pending interrupt conditions and reads the final status. If the interface did not become controller, the sequencer takes it offline again.

At completion the sequencer raises `done` for one cycle. At the same time it presents either the equal condition, meaning the interface is controller, or the greater condition, meaning the identity check failed, the status showed no system controller, or controller status was not gained. Both condition outputs hold their value until the next completion. Each access on the register bus takes one cycle: a write asserts `regWe` with an address and data, and a read asserts `regRe` with an address and takes `regRdata` one cycle later.

Top module: `ifc_init_seq`

## Requirements
- R1: After reset, `busy`, `done`, `ccEqual` and `ccGreater` are all low, and neither `regWe` nor `regRe` is asserted.
- R2: The first access is a read of the identity register at address 14. If bit 0 of the returned word is 1, the interface is of a foreign type and the sequencer completes with `ccGreater` after this single read, with no write.
- R3: The second access is a read of the status register at address 1. If its bit 3 (system controller) is 0, the sequencer completes with `ccGreater` after exactly two reads, with no write.
- R4: When both checks pass, the first three writes are, in this order: 0x0008 (octal 10) to the poll-response register at address 5, 0x8080 (octal 100200) to the online register at address 7, and 0x0030 (octal 60, remote enable plus interface clear) to the line register at address 6.
- R5: The next write is 0x0020 (octal 40, remote enable only) to the line register at address 6. It occurs only after `IFC_US` (default 100) `usTick` pulses have been counted since the 0x0030 write.
- R6: The write after that is 0xFFFF to the interrupt register at address 2.
- R7: The sequencer then re-reads the status register at address 1. If bit 4 (controller) is 0, it writes 0x0000 to the online register at address 7 as the sixth and last write, and completes with `ccGreater`.
- R8: If bit 4 of that final status read is 1, the sequencer completes with `ccEqual` after exactly five writes and three reads.
- R9: `busy` rises in the cycle after an accepted start strobe and stays high until completion. `done` is a one-cycle pulse in the cycle `busy` falls, and exactly one of `ccEqual` or `ccGreater` is high at that moment.
- R10: A start strobe while `busy` is high is ignored: the run in progress completes exactly once with its normal access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to run the initialise command |
| usTick | input | 1 | One-cycle pulse per microsecond |
| regRdata | input | 16 | Read data from the interface, valid the cycle after `regRe` |
| regWe | output | 1 | Register write enable |
| regRe | output | 1 | Register read enable |
| regAddr | output | 4 | Register address |
| regWdata | output | 16 | Register write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| ccEqual | output | 1 | Equal condition: the interface ended as controller |
| ccGreater | output | 1 | Greater condition: aborted or not controller |

## Verification
The bench counts reads and writes for each of the two early exits. A design that tested the wrong bit or the wrong register would write to the interface when it should stay silent, or it would abort a healthy run. The bench also measures the interface-clear window in ticks between the two line-register writes. A timer that loaded or decremented wrongly would release interface clear early. The bench checks that the offline write appears only when the controller bit is clear, because a design that decoded the final status wrongly would take a working controller offline. A second start strobe in mid-run must not restart or duplicate the sequence.

// File: rtl/ifc_init_pkg.sv
package ifc_init_pkg;

  // Which single register access the control asks the datapath to place on the bus
  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_RD_ID,
    ACC_RD_STAT,
    ACC_WR_POLL,
    ACC_WR_ONLINE,
    ACC_WR_LINE_ON,
    ACC_WR_LINE_OFF,
    ACC_WR_INTR,
    ACC_WR_OFFLINE
  } accSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    accSel_t accSel;
    logic    timerLoad;
    logic    timerRun;
    logic    finishGreater;
    logic    finishEqual;
  } ctlStrobes_t;

endpackage

// File: rtl/ifc_init_dp.sv
module ifc_init_dp
  import ifc_init_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int ID_ADDR     = 14,
  parameter int STAT_ADDR   = 1,
  parameter int INTR_ADDR   = 2,
  parameter int POLL_ADDR   = 5,
  parameter int LINE_ADDR   = 6,
  parameter int ONLINE_ADDR = 7,
  parameter int FOREIGN_BIT = 0,
  parameter int SYSCTL_BIT  = 3,
  parameter int CTRL_BIT    = 4,
  parameter int IFC_US      = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              usTick,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWe,
  output logic              regRe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              flagForeign,
  output logic              flagSysCtl,
  output logic              flagCtrl,
  output logic              timerZero,
  output logic              done,
  output logic              ccEqual,
  output logic              ccGreater
);

  localparam int TIMER_W = $clog2(IFC_US + 1);
  localparam logic [DATA_W-1:0] POLL_VAL     = DATA_W'('o10);
  localparam logic [DATA_W-1:0] ONLINE_VAL   = DATA_W'('o100200);
  localparam logic [DATA_W-1:0] LINE_ON_VAL  = DATA_W'('o60);
  localparam logic [DATA_W-1:0] LINE_OFF_VAL = DATA_W'('o40);
  localparam logic [DATA_W-1:0] INTR_VAL     = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] OFFLINE_VAL  = '0;

  logic [TIMER_W-1:0] timerCnt;

  // Bus drive: one access per cycle
  always_comb begin
    regWe    = 1'b0;
    regRe    = 1'b0;
    regAddr  = '0;
    regWdata = '0;
    unique case (strobes.accSel)
      ACC_RD_ID:       begin regRe = 1'b1; regAddr = ADDR_W'(ID_ADDR); end
      ACC_RD_STAT:     begin regRe = 1'b1; regAddr = ADDR_W'(STAT_ADDR); end
      ACC_WR_POLL:     begin regWe = 1'b1; regAddr = ADDR_W'(POLL_ADDR);   regWdata = POLL_VAL; end
      ACC_WR_ONLINE:   begin regWe = 1'b1; regAddr = ADDR_W'(ONLINE_ADDR); regWdata = ONLINE_VAL; end
      ACC_WR_LINE_ON:  begin regWe = 1'b1; regAddr = ADDR_W'(LINE_ADDR);   regWdata = LINE_ON_VAL; end
      ACC_WR_LINE_OFF: begin regWe = 1'b1; regAddr = ADDR_W'(LINE_ADDR);   regWdata = LINE_OFF_VAL; end
      ACC_WR_INTR:     begin regWe = 1'b1; regAddr = ADDR_W'(INTR_ADDR);   regWdata = INTR_VAL; end
      ACC_WR_OFFLINE:  begin regWe = 1'b1; regAddr = ADDR_W'(ONLINE_ADDR); regWdata = OFFLINE_VAL; end
      default: ;
    endcase
  end

  // Status decode of the word returned by the previous read
  assign flagForeign = regRdata[FOREIGN_BIT];
  assign flagSysCtl  = regRdata[SYSCTL_BIT];
  assign flagCtrl    = regRdata[CTRL_BIT];

  // Interface-clear hold timer, counted in microsecond ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (strobes.timerLoad) begin
      timerCnt <= TIMER_W'(IFC_US);
    end else if (strobes.timerRun && usTick && timerCnt != '0) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  assign timerZero = (timerCnt == '0);

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      ccEqual   <= 1'b0;
      ccGreater <= 1'b0;
    end else begin
      done <= strobes.finishGreater | strobes.finishEqual;
      if (strobes.finishGreater) begin
        ccGreater <= 1'b1;
        ccEqual   <= 1'b0;
      end else if (strobes.finishEqual) begin
        ccGreater <= 1'b0;
        ccEqual   <= 1'b1;
      end
    end
  end

  AST_IFC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(LINE_ADDR) && regWdata == LINE_OFF_VAL) |-> (timerCnt == '0)) else $error("clear released early"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R9

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({ccEqual, ccGreater})) else $error("condition not one-hot"); // R9

endmodule

// File: rtl/ifc_init_ctrl.sv
module ifc_init_ctrl
  import ifc_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        flagForeign,
  input  logic        flagSysCtl,
  input  logic        flagCtrl,
  input  logic        timerZero,
  output ctlStrobes_t strobes,
  output logic        busy
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_ID,
    S_CHK_ID,
    S_RD_STAT,
    S_CHK_STAT,
    S_WR_POLL,
    S_WR_ONLINE,
    S_WR_LINE_ON,
    S_WAIT_IFC,
    S_WR_LINE_OFF,
    S_WR_INTR,
    S_RD_FINAL,
    S_CHK_FINAL,
    S_WR_OFFLINE
  } state_t;

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '{accSel: ACC_NONE, timerLoad: 1'b0, timerRun: 1'b0,
                  finishGreater: 1'b0, finishEqual: 1'b0};
    unique case (state)
      S_IDLE:       if (startPulse) stateNext = S_RD_ID;
      S_RD_ID:      begin strobes.accSel = ACC_RD_ID; stateNext = S_CHK_ID; end
      S_CHK_ID: begin
        if (flagForeign) begin
          strobes.finishGreater = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_RD_STAT;
        end
      end
      S_RD_STAT:    begin strobes.accSel = ACC_RD_STAT; stateNext = S_CHK_STAT; end
      S_CHK_STAT: begin
        if (!flagSysCtl) begin
          strobes.finishGreater = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_WR_POLL;
        end
      end
      S_WR_POLL:    begin strobes.accSel = ACC_WR_POLL;   stateNext = S_WR_ONLINE; end
      S_WR_ONLINE:  begin strobes.accSel = ACC_WR_ONLINE; stateNext = S_WR_LINE_ON; end
      S_WR_LINE_ON: begin
        strobes.accSel    = ACC_WR_LINE_ON;
        strobes.timerLoad = 1'b1;
        stateNext         = S_WAIT_IFC;
      end
      S_WAIT_IFC: begin
        strobes.timerRun = 1'b1;
        if (timerZero) stateNext = S_WR_LINE_OFF;
      end
      S_WR_LINE_OFF: begin strobes.accSel = ACC_WR_LINE_OFF; stateNext = S_WR_INTR; end
      S_WR_INTR:     begin strobes.accSel = ACC_WR_INTR;     stateNext = S_RD_FINAL; end
      S_RD_FINAL:    begin strobes.accSel = ACC_RD_STAT;     stateNext = S_CHK_FINAL; end
      S_CHK_FINAL: begin
        if (flagCtrl) begin
          strobes.finishEqual = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_WR_OFFLINE;
        end
      end
      S_WR_OFFLINE: begin
        strobes.accSel        = ACC_WR_OFFLINE;
        strobes.finishGreater = 1'b1;
        stateNext             = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy) else $error("start not taken"); // R9

  AST_FOREIGN_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHK_ID && flagForeign) |=> !busy) else $error("foreign type not aborted"); // R2

  AST_SYSCTL_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHK_STAT && !flagSysCtl) |=> !busy) else $error("non system controller not aborted"); // R3

  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && state != S_RD_ID) |=> (state != S_RD_ID)) else $error("restart while busy"); // R10

endmodule

// File: rtl/ifc_init_seq.sv
module ifc_init_seq
  import ifc_init_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int ID_ADDR     = 14,
  parameter int STAT_ADDR   = 1,
  parameter int INTR_ADDR   = 2,
  parameter int POLL_ADDR   = 5,
  parameter int LINE_ADDR   = 6,
  parameter int ONLINE_ADDR = 7,
  parameter int FOREIGN_BIT = 0,
  parameter int SYSCTL_BIT  = 3,
  parameter int CTRL_BIT    = 4,
  parameter int IFC_US      = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              usTick,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWe,
  output logic              regRe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              busy,
  output logic              done,
  output logic              ccEqual,
  output logic              ccGreater
);

  ctlStrobes_t strobes;
  logic flagForeign, flagSysCtl, flagCtrl, timerZero;

  ifc_init_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .flagForeign (flagForeign),
    .flagSysCtl  (flagSysCtl),
    .flagCtrl    (flagCtrl),
    .timerZero   (timerZero),
    .strobes     (strobes),
    .busy        (busy)
  );

  ifc_init_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ID_ADDR     (ID_ADDR),
    .STAT_ADDR   (STAT_ADDR),
    .INTR_ADDR   (INTR_ADDR),
    .POLL_ADDR   (POLL_ADDR),
    .LINE_ADDR   (LINE_ADDR),
    .ONLINE_ADDR (ONLINE_ADDR),
    .FOREIGN_BIT (FOREIGN_BIT),
    .SYSCTL_BIT  (SYSCTL_BIT),
    .CTRL_BIT    (CTRL_BIT),
    .IFC_US      (IFC_US)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .usTick      (usTick),
    .regRdata    (regRdata),
    .regWe       (regWe),
    .regRe       (regRe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .flagForeign (flagForeign),
    .flagSysCtl  (flagSysCtl),
    .flagCtrl    (flagCtrl),
    .timerZero   (timerZero),
    .done        (done),
    .ccEqual     (ccEqual),
    .ccGreater   (ccGreater)
  );

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe)) else $error("two accesses in one cycle"); // R1

endmodule

// File: tb/ifc_init_seq_test.sv
module ifc_init_seq_test;

  localparam int IFC_US = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        usTick = 1'b0;
  logic [15:0] regRdata;
  logic        regWe, regRe;
  logic [3:0]  regAddr;
  logic [15:0] regWdata;
  logic        busy, done, ccEqual, ccGreater;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ifc_init_seq uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .usTick(usTick),
    .regRdata(regRdata), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .busy(busy), .done(done), .ccEqual(ccEqual),
    .ccGreater(ccGreater)
  );

  // Register file stub
  logic [15:0] mem [16];
  int writeCount = 0;
  int readCount = 0;
  int tickTotal = 0;
  int doneCount = 0;
  logic [3:0]  logAddr [64];
  logic [15:0] logData [64];
  int          logTicks [64];

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (regRe) regRdata <= mem[regAddr];
    if (regRe) readCount <= readCount + 1;
    if (regWe) begin
      logAddr[writeCount % 64]  <= regAddr;
      logData[writeCount % 64]  <= regWdata;
      logTicks[writeCount % 64] <= tickTotal;
      writeCount <= writeCount + 1;
    end
    if (usTick) tickTotal <= tickTotal + 1;
    if (done) doneCount <= doneCount + 1;
  end

  initial begin
    forever begin
      @(negedge clk); usTick = 1'b0;
      @(negedge clk); @(negedge clk); @(negedge clk); usTick = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runInit(output logic gr, output logic eq);
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int i = 0; i < 2000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(busy == 1'b0, "R9 busy low at done", busy, 0);
    gr = ccGreater; eq = ccEqual;
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0, "R1 busy/done reset", {busy, done}, 0);
    check(ccEqual == 0 && ccGreater == 0, "R1 cc reset", {ccEqual, ccGreater}, 0);
    check(regWe == 0 && regRe == 0, "R1 bus idle", {regWe, regRe}, 0);
  endtask

  task automatic testForeign();
    int w0, r0; logic gr, eq;
    mem[14] = 16'h0001; mem[1] = 16'h0018;
    w0 = writeCount; r0 = readCount;
    runInit(gr, eq);
    check(gr == 1 && eq == 0, "R2 greater on foreign", {gr, eq}, 2);
    check(writeCount - w0 == 0, "R2 no writes", writeCount - w0, 0);
    check(readCount - r0 == 1, "R2 one read", readCount - r0, 1);
  endtask

  task automatic testNotSysCtl();
    int w0, r0; logic gr, eq;
    mem[14] = 16'h0000; mem[1] = 16'h0010;
    w0 = writeCount; r0 = readCount;
    runInit(gr, eq);
    check(gr == 1 && eq == 0, "R3 greater on no sysctl", {gr, eq}, 2);
    check(writeCount - w0 == 0, "R3 no writes", writeCount - w0, 0);
    check(readCount - r0 == 2, "R3 two reads", readCount - r0, 2);
  endtask

  task automatic checkCommon(input int b);
    check(logAddr[b % 64] == 5 && logData[b % 64] == 16'h0008, "R4 poll write", logData[b % 64], 16'h0008);
    check(logAddr[(b+1) % 64] == 7 && logData[(b+1) % 64] == 16'h8080, "R4 online write", logData[(b+1) % 64], 16'h8080);
    check(logAddr[(b+2) % 64] == 6 && logData[(b+2) % 64] == 16'h0030, "R4 line on write", logData[(b+2) % 64], 16'h0030);
    check(logAddr[(b+3) % 64] == 6 && logData[(b+3) % 64] == 16'h0020, "R5 line off write", logData[(b+3) % 64], 16'h0020);
    begin
      int dt;
      dt = logTicks[(b+3) % 64] - logTicks[(b+2) % 64];
      check(dt >= IFC_US && dt <= IFC_US + 1, "R5 clear window ticks", dt, IFC_US);
    end
    check(logAddr[(b+4) % 64] == 2 && logData[(b+4) % 64] == 16'hFFFF, "R6 interrupt clear write", logData[(b+4) % 64], 16'hFFFF);
  endtask

  task automatic testGainCtrl();
    int w0, r0; logic gr, eq;
    mem[14] = 16'h0000; mem[1] = 16'h0018;
    w0 = writeCount; r0 = readCount;
    runInit(gr, eq);
    check(eq == 1 && gr == 0, "R8 equal when controller", {gr, eq}, 1);
    check(writeCount - w0 == 5, "R8 five writes", writeCount - w0, 5);
    check(readCount - r0 == 3, "R8 three reads", readCount - r0, 3);
    checkCommon(w0);
  endtask

  task automatic testNoCtrl();
    int w0; logic gr, eq;
    mem[14] = 16'h0000; mem[1] = 16'h0008;
    w0 = writeCount;
    runInit(gr, eq);
    check(gr == 1 && eq == 0, "R7 greater when not controller", {gr, eq}, 2);
    check(writeCount - w0 == 6, "R7 six writes", writeCount - w0, 6);
    checkCommon(w0);
    check(logAddr[(w0+5) % 64] == 7 && logData[(w0+5) % 64] == 16'h0000, "R7 offline write", logData[(w0+5) % 64], 0);
  endtask

  task automatic testStartIgnored();
    int w0, d0;
    mem[14] = 16'h0000; mem[1] = 16'h0018;
    w0 = writeCount; d0 = doneCount;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (20) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(ccEqual == 1, "R10 run completes equal", ccEqual, 1);
    repeat (10) @(negedge clk);
    check(busy == 0, "R10 no restart", busy, 0);
    check(writeCount - w0 == 5, "R10 write count unchanged", writeCount - w0, 5);
    check(doneCount - d0 == 1, "R10 single completion", doneCount - d0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testForeign();
    testNotSysCtl();
    testGainCtrl();
    testNoCtrl();
    testStartIgnored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule